// File: doc/BRIEF.md
# I2C Target Address Front-End

This block sits on the two wires of an I2C bus as a passive target. It oversamples SCL and SDA on a fast system clock. From the samples it picks out start and stop conditions, keeps a bus-busy flag, and shifts in the first byte that follows every start. It then sorts the 7-bit address into a class. When the address belongs to this target, it acknowledges by pulling SDA low through an open-drain enable.

The sorting separates the target's own address from the general call, the null address, the extension group (upper four bits all ones) and the remaining reserved low group. A repeated start restarts address capture while the bus stays busy. The data bytes that follow the address are left to other logic.

Top module: `i2c_addr_frontend`

## Requirements
- R1: SDA falling while SCL is high produces exactly one one-cycle `start_pulse`.
- R2: SDA rising while SCL is high produces exactly one one-cycle `stop_pulse`.
- R3: `bus_busy` rises with a start and falls only with a stop. A repeated start leaves it high.
- R4: SDA toggling while SCL is low produces no start or stop pulse and does not change `bus_busy`.
- R5: Eight SCL rising edges after a start give a one-cycle `addr_valid`. SDA is sampled on each SCL rise, most significant bit first. `addr_out` holds bits 7..1 of the byte and `rw_out` holds bit 0. Both hold until the next `addr_valid`.
- R6: `addr_class` encodes the address as follows:
  - 1: the address equals `own_addr`.
  - 2: 0000000.
  - 3: 0000001.
  - 4: any address of the form 1111xxx.
  - 5: any other 0000xxx address.
  - 0: any other address.
  - Classes 2 to 5 take priority over class 1.
- R7: When the address hits, `sda_oe` is high from the SCL fall after the eighth bit to the SCL fall that ends the ninth bit. A hit is class 1, or class 2 with `gc_en` high. `sda_oe` is low at all other times, and `addr_ack` reports the hit.
- R8: With `gc_en` low, a general call is classified as class 2 but is not acknowledged.
- R9: A repeated start in the middle of a byte discards the partial bits, and capture restarts from the next SCL rise.
- R10: A stop in the middle of the address byte aborts capture, and no `addr_valid` is produced.
- R11: After reset, `bus_busy`, `start_pulse`, `stop_pulse`, `addr_valid` and `sda_oe` are low.
- R12: Bytes after the acknowledge slot produce no `addr_valid` and are never acknowledged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| own_addr | input | 7 | This target's 7-bit address |
| gc_en | input | 1 | Allow acknowledging the general call |
| sda_oe | output | 1 | High pulls SDA low (open-drain) |
| bus_busy | output | 1 | Bus held between start and stop |
| start_pulse | output | 1 | One-cycle start strobe |
| stop_pulse | output | 1 | One-cycle stop strobe |
| addr_valid | output | 1 | One-cycle strobe, address byte captured |
| addr_out | output | 7 | Captured address |
| rw_out | output | 1 | Captured direction bit (1 = read) |
| addr_class | output | 3 | Address class code (see R6) |
| addr_ack | output | 1 | Captured address was acknowledged |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 rather than the default 2. Each SCL quarter-phase lasts ten system clocks. This checks that detection and the acknowledge window stay correct when the synchroniser delay is longer. The bench also models the open-drain wire, so the acknowledge it observes is the real wire level. Random own addresses and random `gc_en` values, with addresses biased toward each reserved group, bring every class and both general-call outcomes within reach.

// File: rtl/i2c_af_pkg.sv
// Shared constants and the address class type for the I2C address front-end.
package i2c_af_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;

    typedef enum logic [2:0] {
        CLS_PLAIN = 3'd0,
        CLS_OWN   = 3'd1,
        CLS_GCALL = 3'd2,
        CLS_NULL  = 3'd3,
        CLS_EXT   = 3'd4,
        CLS_RSVD  = 3'd5
    } addr_cls_e;
endpackage

// File: rtl/i2c_af_sync.sv
// Multi-flop synchroniser for asynchronous bus wires.
// Assumes: inputs idle high, so reset loads ones to avoid false edges.
module i2c_af_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the raw wire levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/i2c_af_cond.sv
// Bus condition detector: SCL edges, start/stop conditions and busy flag.
// Assumes synchronised inputs and a system clock far faster than SCL.
module i2c_af_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p,
    output logic busy
);
    logic scl_q, sda_q;

    // Remember the previous synchronised wire levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Classify the current cycle's transitions.
    always_comb begin
        start_det = scl_s && scl_q && sda_q && !sda_s;
        stop_det  = scl_s && scl_q && !sda_q && sda_s;
        scl_rise  = scl_s && !scl_q;
        scl_fall  = !scl_s && scl_q;
    end

    // Register the strobes and track bus ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_p <= 1'b0;
            stop_p  <= 1'b0;
            busy    <= 1'b0;
        end else begin
            start_p <= start_det;
            stop_p  <= stop_det;
            if (start_det)     busy <= 1'b1;
            else if (stop_det) busy <= 1'b0;
        end
    end

    a_r1_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> !start_p);
    a_r2_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !stop_p);
    a_r3_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |-> busy);
    a_r3_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |-> !busy);
    a_r3_busy_falls_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> stop_p);
    a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_p && stop_p));
endmodule

// File: rtl/i2c_af_classify.sv
// Address sorter: maps a 7-bit address to its class and decides the acknowledge.
// Purely combinational; reserved groups outrank the own-address compare.
module i2c_af_classify
    import i2c_af_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    output addr_cls_e         cls,
    output logic              hit
);
    localparam int GRP_W = ADDR_W - 3;

    logic [GRP_W-1:0] grp;
    assign grp = addr[ADDR_W-1 -: GRP_W];

    // Priority sort: special codes, then groups, then own compare.
    always_comb begin
        if (addr == '0)                       cls = CLS_GCALL;
        else if (addr == ADDR_W'(1))          cls = CLS_NULL;
        else if (grp == '1)                   cls = CLS_EXT;
        else if (grp == '0)                   cls = CLS_RSVD;
        else if (addr == own_addr)            cls = CLS_OWN;
        else                                  cls = CLS_PLAIN;
    end

    // Acknowledge on own address, or general call when enabled.
    assign hit = (cls == CLS_OWN) || ((cls == CLS_GCALL) && gc_en);
endmodule

// File: rtl/i2c_af_capture.sv
// Address byte capture and acknowledge sequencer.
// Shifts SDA on SCL rises after a start, latches the sorted result on the
// eighth bit, then holds SDA low across the ninth clock on a hit.
module i2c_af_capture
    import i2c_af_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  addr_cls_e         cls_in,
    input  logic              hit_in,
    output logic [BYTE_W-1:0] byte_next,
    output logic              valid,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rw_q,
    output addr_cls_e         cls_q,
    output logic              match_q,
    output logic              oe
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WAIT_ACK, ST_ACK} cap_st_e;

    cap_st_e          st;
    logic [CNT_W-1:0] cnt;
    logic [BYTE_W-1:0] shreg;

    // Byte value as it will be after the current SCL rise.
    assign byte_next = {shreg[BYTE_W-2:0], sda_s};

    // Capture sequencer with start/stop override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            valid   <= 1'b0;
            addr_q  <= '0;
            rw_q    <= 1'b0;
            cls_q   <= CLS_PLAIN;
            match_q <= 1'b0;
            oe      <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (stop_det) begin
                st  <= ST_IDLE;
                cnt <= '0;
                oe  <= 1'b0;
            end else if (start_det) begin
                st  <= ST_ADDR;
                cnt <= '0;
                oe  <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: if (scl_rise) begin
                        shreg <= byte_next;
                        cnt   <= cnt + 1'b1;
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            valid   <= 1'b1;
                            addr_q  <= byte_next[BYTE_W-1:1];
                            rw_q    <= byte_next[0];
                            cls_q   <= cls_in;
                            match_q <= hit_in;
                            st      <= ST_WAIT_ACK;
                        end
                    end
                    ST_WAIT_ACK: if (scl_fall) begin
                        oe <= match_q;
                        st <= match_q ? ST_ACK : ST_IDLE;
                    end
                    ST_ACK: if (scl_fall) begin
                        oe <= 1'b0;
                        st <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r7_drive_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> match_q);
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    a_r7_no_drive_at_valid: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !oe);
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !oe);
    a_r5_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(addr_q));
endmodule

// File: rtl/i2c_addr_frontend.sv
// I2C target address front-end top: synchroniser, condition detector,
// byte capture and address sorter. Runs on a clock far faster than SCL.
module i2c_addr_frontend
    import i2c_af_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [6:0] own_addr,
    input  logic       gc_en,
    output logic       sda_oe,
    output logic       bus_busy,
    output logic       start_pulse,
    output logic       stop_pulse,
    output logic       addr_valid,
    output logic [6:0] addr_out,
    output logic       rw_out,
    output logic [2:0] addr_class,
    output logic       addr_ack
);
    logic [1:0]        wires_s;
    logic              start_det, stop_det, scl_rise, scl_fall;
    logic [BYTE_W-1:0] byte_next;
    addr_cls_e         cls_c, cls_q;
    logic              hit_c;

    i2c_af_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(wires_s)
    );

    i2c_af_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(wires_s[1]), .sda_s(wires_s[0]),
        .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_pulse), .stop_p(stop_pulse), .busy(bus_busy)
    );

    i2c_af_classify u_cls (
        .addr(byte_next[BYTE_W-1:1]), .own_addr(own_addr), .gc_en(gc_en),
        .cls(cls_c), .hit(hit_c)
    );

    i2c_af_capture u_cap (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(wires_s[0]),
        .cls_in(cls_c), .hit_in(hit_c), .byte_next(byte_next),
        .valid(addr_valid), .addr_q(addr_out), .rw_q(rw_out),
        .cls_q(cls_q), .match_q(addr_ack), .oe(sda_oe)
    );

    assign addr_class = cls_q;

    a_r7_ack_reported: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> addr_ack && bus_busy);
endmodule

// File: tb/sim_i2c_addr_frontend.sv
module sim_i2c_addr_frontend;
    localparam int Q = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_drv = 1'b1, sda_drv = 1'b1;
    logic [6:0] own_addr = 7'h2A;
    logic gc_en = 1'b0;
    logic sda_oe, bus_busy, start_pulse, stop_pulse, addr_valid, rw_out, addr_ack;
    logic [6:0] addr_out;
    logic [2:0] addr_class;
    wire  sda_line = sda_drv & ~sda_oe;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int n_start = 0, n_stop = 0, n_valid = 0, n_busy_fall = 0;
    logic busy_prev = 1'b0;
    bit done = 0;

    always #5 clk = ~clk;

    i2c_addr_frontend #(.SYNC_STAGES(3)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .own_addr(own_addr), .gc_en(gc_en), .sda_oe(sda_oe), .bus_busy(bus_busy),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .addr_valid(addr_valid),
        .addr_out(addr_out), .rw_out(rw_out), .addr_class(addr_class), .addr_ack(addr_ack)
    );

    // Event monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_start += int'(start_pulse);
            n_stop  += int'(stop_pulse);
            n_valid += int'(addr_valid);
            if (busy_prev && !bus_busy) n_busy_fall++;
            busy_prev = bus_busy;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_class(input logic [6:0] a, input logic [6:0] own);
        if (a == 7'd0) return 2;
        if (a == 7'd1) return 3;
        if (a[6:3] == 4'hF) return 4;
        if (a[6:3] == 4'h0) return 5;
        if (a == own) return 1;
        return 0;
    endfunction

    function automatic bit exp_hit(input int c, input bit g);
        return (c == 1) || (c == 2 && g);
    endfunction

    task automatic waitq(input int n);
        repeat (n * Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start;
        sda_drv = 1; waitq(1); scl_drv = 1; waitq(1);
        sda_drv = 0; waitq(1); scl_drv = 0; waitq(1);
    endtask

    task automatic bus_stop;
        sda_drv = 0; waitq(1); scl_drv = 1; waitq(1); sda_drv = 1; waitq(2);
    endtask

    task automatic send_bit(input bit b, output bit oe_hi);
        scl_drv = 0; waitq(1); sda_drv = b; waitq(1);
        scl_drv = 1; waitq(1); oe_hi = sda_oe; waitq(1);
        scl_drv = 0;
    endtask

    // Sends a byte and runs the ninth clock; reports wire ack and oe levels.
    task automatic send_byte(input logic [7:0] b, output bit acked,
                             output bit oe8, output bit oe_after);
        bit t;
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i], t);
            if (i == 0) oe8 = t;
        end
        waitq(1); sda_drv = 1; waitq(1);
        scl_drv = 1; waitq(1); acked = ~sda_line; waitq(1);
        scl_drv = 0; waitq(1); oe_after = sda_oe;
    endtask

    initial begin
        bit ack, oe8, oea, t;
        int s0, p0, v0, f0, c;
        logic [6:0] a;
        logic rw;
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk({bus_busy, start_pulse, stop_pulse, addr_valid, sda_oe} == 5'b0, "R11",
            int'({bus_busy, start_pulse, stop_pulse, addr_valid, sda_oe}), 0);
        waitq(1);

        // R4: SDA toggles with SCL low, bus idle
        s0 = n_start; p0 = n_stop;
        scl_drv = 0; waitq(1);
        for (int i = 0; i < 6; i++) begin sda_drv = ~sda_drv; waitq(1); end
        sda_drv = 1; waitq(1); scl_drv = 1; waitq(1);
        chk(n_start == s0 && n_stop == p0, "R4", n_start - s0 + n_stop - p0, 0);
        chk(bus_busy == 0, "R4", bus_busy, 0);

        // R9: repeated start mid-byte, busy held
        own_addr = 7'h3C; gc_en = 0;
        s0 = n_start; v0 = n_valid; f0 = n_busy_fall;
        bus_start;
        for (int i = 0; i < 4; i++) send_bit(i[0], t);
        bus_start;
        chk(bus_busy == 1, "R9", bus_busy, 1);
        send_byte({7'h3C, 1'b0}, ack, oe8, oea);
        chk(n_valid == v0 + 1, "R9", n_valid - v0, 1);
        chk(addr_out == 7'h3C, "R9", addr_out, 7'h3C);
        chk(ack == 1, "R9", ack, 1);
        chk(n_busy_fall == f0, "R3", n_busy_fall - f0, 0);
        chk(n_start == s0 + 2, "R1", n_start - s0, 2);
        // R4 with bus busy: toggling under SCL low
        s0 = n_start; p0 = n_stop;
        for (int i = 0; i < 4; i++) begin sda_drv = ~sda_drv; waitq(1); end
        chk(n_start == s0 && n_stop == p0 && bus_busy, "R4", n_start - s0 + n_stop - p0, 0);
        bus_stop;
        chk(bus_busy == 0, "R3", bus_busy, 0);

        // R10: stop mid-byte aborts
        v0 = n_valid;
        bus_start;
        for (int i = 0; i < 5; i++) send_bit(1'b1, t);
        bus_stop;
        chk(n_valid == v0, "R10", n_valid - v0, 0);
        chk(bus_busy == 0 && sda_oe == 0, "R10", bus_busy, 0);

        // R12: following byte ignored
        v0 = n_valid;
        bus_start;
        send_byte({7'h3C, 1'b0}, ack, oe8, oea);
        chk(ack == 1, "R7", ack, 1);
        gc_en = 1;
        send_byte(8'h00, ack, oe8, oea);
        chk(n_valid == v0 + 1, "R12", n_valid - v0, 1);
        chk(ack == 0 && oea == 0, "R12", ack, 0);
        chk(addr_out == 7'h3C, "R12", addr_out, 7'h3C);
        bus_stop;

        // Random transactions: R1 R2 R3 R5 R6 R7 R8
        for (int it = 0; it < 48; it++) begin
            own_addr = 7'h08 + 7'($urandom % 112);
            gc_en = 1'($urandom);
            rw = 1'($urandom);
            case ($urandom % 6)
                0: a = own_addr;
                1: a = 7'd0;
                2: a = 7'd1;
                3: a = {4'hF, 3'($urandom)};
                4: a = {4'h0, 3'd2 + 3'($urandom % 6)};
                default: a = 7'($urandom);
            endcase
            c = exp_class(a, own_addr);
            s0 = n_start; p0 = n_stop; v0 = n_valid;
            bus_start;
            send_byte({a, rw}, ack, oe8, oea);
            bus_stop;
            chk(n_start == s0 + 1, "R1", n_start - s0, 1);
            chk(n_stop == p0 + 1, "R2", n_stop - p0, 1);
            chk(bus_busy == 0, "R3", bus_busy, 0);
            chk(n_valid == v0 + 1, "R5", n_valid - v0, 1);
            chk(addr_out == a && rw_out == rw, "R5", {addr_out, rw_out}, {a, rw});
            chk(int'(addr_class) == c, "R6", addr_class, c);
            if (c == 2) chk(ack == gc_en, "R8", ack, gc_en);
            else        chk(ack == exp_hit(c, gc_en), "R7", ack, exp_hit(c, gc_en));
            chk(addr_ack == exp_hit(c, gc_en), "R7", addr_ack, exp_hit(c, gc_en));
            chk(oe8 == 0 && oea == 0, "R7", {oe8, oea}, 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule